// File: doc/BRIEF.md
# Memory Address Line Tester

This block is a built-in self-test controller for a RAM that sits behind a simple synchronous port. A single read or write request goes out per cycle, and read data comes back one cycle after the request. The controller looks for addressing faults: address lines that are stuck, open or shorted, and decode errors that make two addresses land in the same cell. To find them it uses data derived from the addresses themselves, in two sub-tests that always run in the same order.

The first sub-test uses single-bit addresses. It writes a distinct marker to address zero and to every address that has exactly one bit set. It then reads the same set of addresses back. When two of these addresses map to one cell, the marker written later overwrites the earlier one, and the read-back shows it. The second sub-test sweeps the whole range. It writes every location with its own address value, and it finishes the entire write sweep before it starts a read sweep that checks each location.

Every mismatch raises a one-cycle error strobe. The strobe carries the address that failed, the data actually read, and which sub-test found it. When both sub-tests are complete, the controller raises a done flag together with a pass/fail verdict. Both flags hold until the next start.

Top module: `addr_line_bist`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `err_valid`, `mem_en` and `mem_we` are all 0.
- R2: A `start` pulse while idle launches a run. A `start` while `busy` is high has no effect: the request sequence continues unchanged and holds exactly one run's worth of requests.
- R3: The first phase writes index k = 0..ADDR_W, in ascending order. Index 0 goes to address 0, and index k >= 1 goes to the address with only bit k-1 set. The data is the marker k+1, zero-extended to DATA_W.
- R4: Once all first-phase writes are done, the same ADDR_W+1 addresses are read in the same order. Each read is compared against its marker.
- R5: The second phase writes every address from 0 to 2^ADDR_W-1 in ascending order. The data is the address itself, zero-extended or truncated to DATA_W.
- R6: The second-phase reads begin only after the last address of the write sweep has been written. They visit every address in ascending order and compare each against its own address value.
- R7: For each mismatch, `err_valid` is high for exactly one cycle, two cycles after the cycle in which the read was requested. In that cycle `err_addr` holds the requested address and `err_data` holds the data read. `err_phase` is 0 for the first phase and 1 for the second.
- R8: `done` rises three cycles after the final read request, in the same cycle that `busy` falls. `pass` is 1 only if no mismatch occurred. Both hold until the next accepted `start`, which clears them.
- R9: The requests of a run are issued on consecutive cycles with no gaps, 2*(ADDR_W+1) + 2*2^ADDR_W of them in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a test run; sampled only when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | No mismatch in the finished run |
| mem_en | output | 1 | RAM request valid |
| mem_we | output | 1 | RAM request is a write |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read request |
| err_valid | output | 1 | Mismatch strobe, one cycle per failing read |
| err_phase | output | 1 | 0 = single-bit-address phase, 1 = own-address phase |
| err_addr | output | ADDR_W | Address of the failing read |
| err_data | output | DATA_W | Data returned by the failing read |

## Verification
The bench connects a behavioural RAM model and injects three kinds of fault into it: an address bit stuck at 0, an address bit stuck at 1, and a single corrupted cell at an address that is not a one-bit address. A controller that read back before finishing its writes, or that skipped address zero, would miss the aliasing in the first phase. One that reused a single marker value would see the aliased cell hold the "right" value. The bench also checks error counts and the exact error data, so a wrong or truncated own-address pattern shows up as an inflated or empty error list. Further checks cover the precise error-strobe and done latencies, the exact request order, and a start pulse sent mid-run. A controller that restarted on that pulse, or whose pipeline tagged errors with the wrong address, would fail them.

// File: rtl/addr_line_pkg.sv
package addr_line_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WO_WR = 3'd1,
    ST_WO_RD = 3'd2,
    ST_OA_WR = 3'd3,
    ST_OA_RD = 3'd4,
    ST_DRAIN = 3'd5
  } alt_state_e;

  typedef enum logic {
    PH_WALK = 1'b0,
    PH_SELF = 1'b1
  } alt_phase_e;

endpackage

// File: rtl/alt_sequencer.sv
module alt_sequencer
  import addr_line_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              start_acc,
  output logic              busy,
  output logic              fin,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_issue,
  output logic [DATA_W-1:0] rd_exp,
  output alt_phase_e        rd_phase
);

  localparam int CNT_W = ADDR_W + 1;
  localparam int MIN_W = (DATA_W < CNT_W) ? DATA_W : CNT_W;
  localparam logic [CNT_W-1:0] WO_LAST = CNT_W'(ADDR_W);

  alt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             drain_q, drain_d;

  // Address of walking index: 0 -> zero, k -> only bit k-1 set.
  function automatic logic [ADDR_W-1:0] walk_addr(input logic [CNT_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    for (int i = 0; i < ADDR_W; i++) a[i] = (idx == CNT_W'(i + 1));
    return a;
  endfunction

  // Zero-extend or truncate a counter-width value into the data width.
  function automatic logic [DATA_W-1:0] fit_data(input logic [CNT_W-1:0] v);
    logic [DATA_W-1:0] d;
    d = '0;
    for (int i = 0; i < MIN_W; i++) d[i] = v[i];
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] walk_marker(input logic [CNT_W-1:0] idx);
    return fit_data(idx) + DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] self_data(input logic [ADDR_W-1:0] a);
    return fit_data({1'b0, a});
  endfunction

  logic in_walk, wo_last, oa_last;
  assign in_walk = (state_q == ST_WO_WR) || (state_q == ST_WO_RD);
  assign wo_last = (cnt_q == WO_LAST);
  assign oa_last = &cnt_q[ADDR_W-1:0];

  assign start_acc = (state_q == ST_IDLE) && start;
  assign busy      = (state_q != ST_IDLE);
  assign fin       = (state_q == ST_DRAIN) && drain_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drain_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_WO_WR;
        cnt_d   = '0;
      end
      ST_WO_WR: begin
        cnt_d = wo_last ? '0 : cnt_q + 1'b1;
        if (wo_last) state_d = ST_WO_RD;
      end
      ST_WO_RD: begin
        cnt_d = wo_last ? '0 : cnt_q + 1'b1;
        if (wo_last) state_d = ST_OA_WR;
      end
      ST_OA_WR: begin
        cnt_d = oa_last ? '0 : cnt_q + 1'b1;
        if (oa_last) state_d = ST_OA_RD;
      end
      ST_OA_RD: begin
        cnt_d = oa_last ? '0 : cnt_q + 1'b1;
        if (oa_last) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        drain_d = 1'b1;
        if (drain_q) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drain_q <= drain_d;
    end
  end

  logic [DATA_W-1:0] pat;
  assign mem_en    = (state_q == ST_WO_WR) || (state_q == ST_WO_RD) ||
                     (state_q == ST_OA_WR) || (state_q == ST_OA_RD);
  assign mem_we    = (state_q == ST_WO_WR) || (state_q == ST_OA_WR);
  assign mem_addr  = in_walk ? walk_addr(cnt_q) : cnt_q[ADDR_W-1:0];
  assign pat       = in_walk ? walk_marker(cnt_q) : self_data(cnt_q[ADDR_W-1:0]);
  assign mem_wdata = pat;
  assign rd_issue  = (state_q == ST_WO_RD) || (state_q == ST_OA_RD);
  assign rd_exp    = pat;
  assign rd_phase  = in_walk ? PH_WALK : PH_SELF;

  // R3: non-zero walking indices use addresses with one bit set
  p_walk_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && in_walk && cnt_q != '0) |-> ($countones(mem_addr) == 1));

  // R4: walking read-back starts only after the final walking write
  p_walk_rd_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WO_RD && $past(state_q) == ST_WO_WR) |->
      ($past(mem_we) && $past(cnt_q) == WO_LAST));

  // R5: own-address write sweep advances by one address per cycle
  p_self_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OA_WR && $past(state_q) == ST_OA_WR) |->
      (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R6: read sweep entered right after the top address was written
  p_read_after_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OA_RD && $past(state_q) != ST_OA_RD) |->
      ($past(mem_we) && (&$past(mem_addr)) && mem_addr == '0));

  // R2: a start while busy does not alter the running sequence
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q != ST_DRAIN) |=> busy);

endmodule

// File: rtl/alt_checker.sv
module alt_checker
  import addr_line_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  alt_phase_e        rd_phase,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              err_valid,
  output logic              err_phase,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data,
  output logic              fail_q
);

  logic              pv_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pexp_q;
  alt_phase_e        pphase_q;
  logic              mismatch;

  // Compare stage lines up with the one-cycle read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q     <= 1'b0;
      paddr_q  <= '0;
      pexp_q   <= '0;
      pphase_q <= PH_WALK;
    end else begin
      pv_q <= rd_issue;
      if (rd_issue) begin
        paddr_q  <= rd_addr;
        pexp_q   <= rd_exp;
        pphase_q <= rd_phase;
      end
    end
  end

  assign mismatch = pv_q && (mem_rdata != pexp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_phase <= 1'b0;
      err_addr  <= '0;
      err_data  <= '0;
      fail_q    <= 1'b0;
    end else begin
      err_valid <= mismatch;
      if (mismatch) begin
        err_phase <= pphase_q;
        err_addr  <= paddr_q;
        err_data  <= mem_rdata;
      end
      fail_q <= clear ? 1'b0 : (fail_q | mismatch);
    end
  end

  // R7: an error strobe always stems from a read compared one cycle earlier
  p_err_from_compare_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(pv_q));

  // R7: strobe address is the address of the read issued two cycles before
  p_err_addr_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_addr == $past(rd_addr, 2) && $past(rd_issue, 2)));

  // R8: a strobe always leaves the sticky fail flag set
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> fail_q);

endmodule

// File: rtl/alt_status.sv
module alt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_acc,
  input  logic fin,
  input  logic fail_q,
  input  logic busy,
  output logic done,
  output logic pass
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else if (start_acc) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else if (fin) begin
      done <= 1'b1;
      pass <= ~fail_q;
    end
  end

  // R8: done only rises at the end of a drain
  p_done_after_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  // R8: pass is never claimed without done
  p_pass_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  // R8: done and busy never overlap
  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/addr_line_bist.sv
module addr_line_bist
  import addr_line_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              err_valid,
  output logic              err_phase,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data
);

  logic              start_acc;
  logic              fin;
  logic              rd_issue;
  logic [DATA_W-1:0] rd_exp;
  alt_phase_e        rd_phase;
  logic              fail_q;

  alt_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_acc (start_acc),
    .busy      (busy),
    .fin       (fin),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_issue  (rd_issue),
    .rd_exp    (rd_exp),
    .rd_phase  (rd_phase)
  );

  alt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .rd_issue  (rd_issue),
    .rd_addr   (mem_addr),
    .rd_exp    (rd_exp),
    .rd_phase  (rd_phase),
    .mem_rdata (mem_rdata),
    .err_valid (err_valid),
    .err_phase (err_phase),
    .err_addr  (err_addr),
    .err_data  (err_data),
    .fail_q    (fail_q)
  );

  alt_status sts_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .fin       (fin),
    .fail_q    (fail_q),
    .busy      (busy),
    .done      (done),
    .pass      (pass)
  );

  // R1: no request leaves the block while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !mem_we));

  // R9: requests never pause between launch and final read
  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_en) && mem_en == 1'b0 && busy) |-> $past(!mem_we));

endmodule

// File: tb/addr_line_bist_tb_top.sv
`timescale 1ns/1ps
module addr_line_bist_tb_top;

  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NWALK = AW + 1;
  localparam int NREQ  = 2 * NWALK + 2 * DEPTH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, pass, mem_en, mem_we, err_valid, err_phase;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_data;

  always #2 clk = ~clk;

  addr_line_bist #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .err_valid(err_valid), .err_phase(err_phase),
    .err_addr(err_addr), .err_data(err_data)
  );

  // Behavioural RAM with fault injection.
  logic [DW-1:0] ram [DEPTH];
  logic [AW-1:0] stk0 = '0, stk1 = '0, flip_addr = '0;
  logic          flip_en = 1'b0, clr_req = 1'b0;

  function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
    return (a & ~stk0) | stk1;
  endfunction

  always @(posedge clk) begin
    if (clr_req) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else if (mem_en && mem_we) begin
      ram[phys(mem_addr)] <= mem_wdata;
    end
    if (mem_en && !mem_we)
      mem_rdata <= ram[phys(mem_addr)] ^ ((flip_en && mem_addr == flip_addr) ? DW'(1) : DW'(0));
  end

  // Monitor: request and error logs with cycle stamps.
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic          lwe   [8192];
  logic [AW-1:0] laddr [8192];
  logic [DW-1:0] ldata [8192];
  int            lcyc  [8192];
  int            nlog = 0;
  logic [AW-1:0] eaddr [2048];
  logic [DW-1:0] edata [2048];
  logic          eph   [2048];
  int            ecyc  [2048];
  int            nerr = 0;
  int            wide_err = 0;
  logic          err_q = 1'b0;

  always @(negedge clk) begin
    if (rst_n && mem_en && nlog < 8192) begin
      lwe[nlog] <= mem_we; laddr[nlog] <= mem_addr; ldata[nlog] <= mem_wdata;
      lcyc[nlog] <= cyc; nlog <= nlog + 1;
    end
    if (rst_n && err_valid && nerr < 2048) begin
      eaddr[nerr] <= err_addr; edata[nerr] <= err_data; eph[nerr] <= err_phase;
      ecyc[nerr] <= cyc; nerr <= nerr + 1;
    end
    err_q <= err_valid;
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int done_cyc;
  int run_base;
  int err_base;

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_ram();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  // Launch a run; optionally pulse start again mid-run at iteration rs.
  task automatic do_run(input int rs, input bit chk_clear);
    int it;
    clear_ram();
    @(negedge clk);
    run_base = nlog; err_base = nerr;
    pulse_start();
    if (chk_clear) check("R8", "done cleared by start", done, 0);
    it = 0;
    while (!done && it < 5000) begin
      if (it == rs) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      it++;
    end
    done_cyc = cyc;
    @(negedge clk);
  endtask

  // Expected request sequence restated from the requirements.
  task automatic check_sequence(input string tag);
    int bad = 0;
    int bi = -1;
    for (int i = 0; i < NREQ; i++) begin
      logic          ewe;
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      int            k;
      if (i < 2 * NWALK) begin
        k   = (i < NWALK) ? i : i - NWALK;
        ewe = (i < NWALK);
        ea  = (k == 0) ? '0 : AW'(1) << (k - 1);
        ed  = DW'(k + 1);
      end else begin
        k   = (i < 2 * NWALK + DEPTH) ? i - 2 * NWALK : i - 2 * NWALK - DEPTH;
        ewe = (i < 2 * NWALK + DEPTH);
        ea  = AW'(k);
        ed  = DW'(k);
      end
      if (lwe[run_base + i] != ewe || laddr[run_base + i] != ea ||
          (ewe && ldata[run_base + i] != ed) || lcyc[run_base + i] != lcyc[run_base] + i) begin
        bad++;
        if (bi < 0) bi = i;
      end
    end
    check(tag, "request count", nlog - run_base, NREQ);
    check("R3 R4 R5 R6 R9", {tag, " first bad request index"}, bi, -1);
  endtask

  task automatic t_reset();
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "pass", pass, 0);
    check("R1", "err_valid", err_valid, 0);
    check("R1", "mem_en", mem_en, 0);
    check("R1", "mem_we", mem_we, 0);
  endtask

  task automatic t_clean();
    stk0 = '0; stk1 = '0; flip_en = 1'b0;
    do_run(-1, 1'b0);
    check_sequence("R3");
    check("R8", "clean pass", pass, 1);
    check("R8", "clean errors", nerr - err_base, 0);
    check("R8", "done latency", done_cyc - lcyc[run_base + NREQ - 1], 3);
    check("R8", "busy low with done", busy, 0);
    repeat (5) @(negedge clk);
    check("R8", "done held", done, 1);
    check("R8", "pass held", pass, 1);
  endtask

  task automatic t_stuck0();
    int badform = 0;
    stk0 = AW'(8); stk1 = '0; flip_en = 1'b0;
    do_run(-1, 1'b1);
    check("R4", "stuck0 error count", nerr - err_base, 1 + DEPTH / 2);
    check("R4", "stuck0 walk err addr", eaddr[err_base], 0);
    check("R4", "stuck0 walk err data", edata[err_base], 5);
    check("R7", "stuck0 walk err phase", eph[err_base], 0);
    for (int i = 1; i < nerr - err_base; i++)
      if (eaddr[err_base + i][3] || edata[err_base + i] != DW'(eaddr[err_base + i] | AW'(8)) ||
          !eph[err_base + i]) badform++;
    check("R6", "stuck0 self errors form", badform, 0);
    check("R8", "stuck0 fail", pass, 0);
    check("R8", "stuck0 done", done, 1);
  endtask

  task automatic t_stuck1();
    int badform = 0;
    stk0 = '0; stk1 = AW'(128); flip_en = 1'b0;
    do_run(-1, 1'b0);
    check("R4", "stuck1 error count", nerr - err_base, 1 + DEPTH / 2);
    check("R4", "stuck1 walk err addr", eaddr[err_base], 0);
    check("R4", "stuck1 walk err data", edata[err_base], 9);
    for (int i = 1; i < nerr - err_base; i++)
      if (eaddr[err_base + i][7] || edata[err_base + i] != DW'(eaddr[err_base + i] | AW'(128)))
        badform++;
    check("R6", "stuck1 self errors form", badform, 0);
    check("R8", "stuck1 fail", pass, 0);
  endtask

  task automatic t_flip();
    int ridx;
    stk0 = '0; stk1 = '0; flip_en = 1'b1; flip_addr = AW'(8'h5A);
    do_run(-1, 1'b0);
    ridx = run_base + 2 * NWALK + DEPTH + 'h5A;
    check("R5", "flip error count", nerr - err_base, 1);
    check("R7", "flip err addr", eaddr[err_base], 'h5A);
    check("R7", "flip err data", edata[err_base], 'h5B);
    check("R7", "flip err phase", eph[err_base], 1);
    check("R7", "flip err latency", ecyc[err_base] - lcyc[ridx], 2);
    check("R7", "flip read request addr", laddr[ridx], 'h5A);
    check("R8", "flip fail", pass, 0);
  endtask

  task automatic t_restart();
    stk0 = '0; stk1 = '0; flip_en = 1'b0;
    do_run(100, 1'b1);
    check_sequence("R2");
    check("R2", "restart ignored pass", pass, 1);
    check("R2", "restart ignored errors", nerr - err_base, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_stuck0();
    t_stuck1();
    t_flip();
    t_restart();
    check("R7", "err strobe never wider than one cycle", wide_err, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // R7: every strobe from the controller in these runs is isolated or tied to a new read
  always @(negedge clk)
    if (rst_n && err_valid && err_q && flip_en) wide_err <= wide_err + 1;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule